// File: doc/BRIEF.md
# Per-Register Consumer Dependency Tracker

This block keeps, for every physical register, a record of the in-flight instruction that will write it (the producer slot) and a list of the waiting instructions that read it (the consumers). The consumers of a register form a singly linked chain. Its nodes are taken from one node pool that all registers share. A stack of free node indices manages that pool.

A scheduler drives commands through a valid/ready handshake, one command per transfer. A command can add a consumer, take back the newest consumer, write or clear the producer slot, drop a named consumer when it is squashed, or clear the whole structure. Insert, pop, producer set and producer clear each finish in one cycle. A named removal walks the chain one node per cycle. A full clear sweeps one node or one register per cycle. Ready stays low while either of these runs. Combinational query outputs show, for any register picked on the query port, whether its chain is empty and what its producer slot holds. A further output shows whether every chain is empty. Three counters are available: live nodes, removals begun, and nodes stepped over while searching.

Top module: `dep_tracker`

## Requirements
- R1: After reset, every chain is empty, every producer slot is invalid, `all_empty` is 1, `cmd_ready` is 1, `pool_full` is 0, and all three counters read 0.
- R2: Op code 0 (insert) puts `cmd_tag` at the front of the chain of `cmd_reg`. Op code 1 (pop) takes the front node off and returns its tag. So pops give tags newest first. The cycle after a pop is accepted, `resp_valid` is 1, `resp_hit` is 1 and `resp_tag` carries the tag.
- R3: A pop on an empty chain gives `resp_valid`=1 and `resp_hit`=0, and changes no chain and no counter.
- R4: Op code 2 writes `cmd_tag` into the producer slot of `cmd_reg` and marks it valid. Op code 3 marks the slot invalid. Neither one changes any chain or `live_count`.
- R5: `q_empty` is 1 exactly when the chain of `q_reg` holds no node, whatever its producer slot holds. `all_empty` is 1 exactly when every chain is empty.
- R6: Op code 4 (remove) on a non-empty chain adds 1 to `remove_count` and searches from the front for `cmd_tag`. It unlinks the first node that matches and keeps the rest of the chain in order. If the match is k nodes behind the front, `walk_count` grows by k and `cmd_ready` stays low for k+1 cycles after the acceptance cycle.
- R7: A remove on an empty chain has no effect: `cmd_ready` stays high, and `remove_count` and `walk_count` do not change.
- R8: A remove whose tag is not on a chain of n nodes adds n-1 to `walk_count`. It keeps `cmd_ready` low for n cycles, pulses `rm_miss` for one cycle as the search ends, and leaves the chain unchanged.
- R9: When all pool nodes are in use, `pool_full` is 1 and an insert is not accepted (`cmd_ready`=0 while `cmd_op`=0). Other commands are still accepted.
- R10: Op code 5 frees every node and invalidates every producer slot. `cmd_ready` stays low for NUM_REGS plus the number of live nodes cycles. Afterwards the whole pool can be used again.
- R11: `live_count` rises by one on each insert and falls by one for each node that a pop, a remove or a full clear frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid is also high |
| cmd_op | input | 3 | 0 insert, 1 pop, 2 set producer, 3 clear producer, 4 remove, 5 clear all; 6 and 7 do nothing |
| cmd_reg | input | $clog2(NUM_REGS) | Register index the command applies to |
| cmd_tag | input | TAG_W | Instruction tag for insert, set producer and remove |
| resp_valid | output | 1 | Pop result present (one cycle) |
| resp_hit | output | 1 | Pop found a consumer |
| resp_tag | output | TAG_W | Tag that was popped |
| rm_miss | output | 1 | One-cycle pulse: remove found no matching tag |
| pool_full | output | 1 | No free node left |
| q_reg | input | $clog2(NUM_REGS) | Register to query |
| q_empty | output | 1 | Queried register has no consumers |
| q_prod_vld | output | 1 | Queried register has a producer |
| q_prod_tag | output | TAG_W | Producer tag of the queried register |
| all_empty | output | 1 | No register has a consumer |
| live_count | output | $clog2(POOL_DEPTH+1) | Nodes in use |
| remove_count | output | STAT_W | Removals begun on non-empty chains |
| walk_count | output | STAT_W | Nodes stepped over during removal searches |

## Verification
The bench builds the tracker with four registers, a six-node pool and five-bit tags. With a pool that small, a few inserts use up every node, so the refusal at exhaustion and the sweep after a full clear come within reach. The bench removes from every position of a four-node chain and checks the stall length and the growth of the step counter against the position. It also pops every register past empty. After each command it compares every register's emptiness and producer slot with a model of per-register stacks.

// File: rtl/dtrk_pkg.sv
package dtrk_pkg;

    localparam logic [2:0] OP_INSERT = 3'd0;
    localparam logic [2:0] OP_POP    = 3'd1;
    localparam logic [2:0] OP_SETP   = 3'd2;
    localparam logic [2:0] OP_CLRP   = 3'd3;
    localparam logic [2:0] OP_REMOVE = 3'd4;
    localparam logic [2:0] OP_CLEAR  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_SWEEP = 2'd2
    } trk_state_t;

    function automatic logic is_long_op(input logic [2:0] op);
        return (op == OP_REMOVE) || (op == OP_CLEAR);
    endfunction

endpackage

// File: rtl/dtrk_counter.sv
module dtrk_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (inc && !dec) begin
            value <= value + 1'b1;
        end else if (dec && !inc) begin
            value <= value - 1'b1;
        end
    end
endmodule

// File: rtl/dtrk_freelist.sv
module dtrk_freelist #(
    parameter int DEPTH = 16,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          give,
    input  logic [IW-1:0] give_idx,
    output logic [IW-1:0] top_idx,
    output logic          none_free,
    output logic [CW-1:0] free_cnt
);
    logic [IW-1:0] stk [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] tpos;

    assign tpos      = cnt - 1'b1;
    assign top_idx   = stk[tpos[IW-1:0]];
    assign none_free = (cnt == '0);
    assign free_cnt  = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stk[i] <= IW'(i);
            cnt <= CW'(DEPTH);
        end else if (take && give) begin
            stk[tpos[IW-1:0]] <= give_idx;
        end else if (take) begin
            cnt <= cnt - 1'b1;
        end else if (give) begin
            stk[cnt[IW-1:0]] <= give_idx;
            cnt <= cnt + 1'b1;
        end
    end

    a_r9_no_take_when_empty: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt != '0));
    a_r11_no_give_when_full: assert property (@(posedge clk) disable iff (rst)
        (give && !take) |-> (cnt != CW'(DEPTH)));
endmodule

// File: rtl/dep_tracker.sv
module dep_tracker
    import dtrk_pkg::*;
#(
    parameter int NUM_REGS   = 8,
    parameter int POOL_DEPTH = 16,
    parameter int TAG_W      = 6,
    parameter int STAT_W     = 16,
    localparam int REG_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int NODE_W = (POOL_DEPTH > 1) ? $clog2(POOL_DEPTH) : 1,
    localparam int CNT_W  = $clog2(POOL_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic [TAG_W-1:0]  cmd_tag,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [TAG_W-1:0]  resp_tag,
    output logic              rm_miss,
    output logic              pool_full,
    input  logic [REG_W-1:0]  q_reg,
    output logic              q_empty,
    output logic              q_prod_vld,
    output logic [TAG_W-1:0]  q_prod_tag,
    output logic              all_empty,
    output logic [CNT_W-1:0]  live_count,
    output logic [STAT_W-1:0] remove_count,
    output logic [STAT_W-1:0] walk_count
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [NODE_W-1:0] nxt;
        logic              nxv;
    } node_t;

    node_t             nodes    [POOL_DEPTH];
    logic [NODE_W-1:0] head_ptr [NUM_REGS];
    logic [NUM_REGS-1:0] head_vld;
    logic [TAG_W-1:0]  prod_tag [NUM_REGS];
    logic [NUM_REGS-1:0] prod_vld;

    trk_state_t        st;
    logic [REG_W-1:0]  w_reg;
    logic [TAG_W-1:0]  w_tag;
    logic [NODE_W-1:0] w_cur, w_prev;
    logic              w_athead;

    logic              fire, fl_take, fl_give, fl_empty;
    logic [NODE_W-1:0] fl_give_idx, fl_top;
    logic [CNT_W-1:0]  fl_count;
    logic              live_inc, live_dec, rm_inc, walk_inc;
    logic              w_match;
    node_t             cur_node, cmd_head, sweep_head;

    assign cmd_ready  = (st == ST_IDLE) && !((cmd_op == OP_INSERT) && fl_empty);
    assign fire       = cmd_valid && cmd_ready;
    assign pool_full  = fl_empty;
    assign all_empty  = ~|head_vld;
    assign q_empty    = !head_vld[q_reg];
    assign q_prod_vld = prod_vld[q_reg];
    assign q_prod_tag = prod_tag[q_reg];
    assign cur_node   = nodes[w_cur];
    assign cmd_head   = nodes[head_ptr[cmd_reg]];
    assign sweep_head = nodes[head_ptr[w_reg]];
    assign w_match    = (cur_node.tag == w_tag);

    always_comb begin
        fl_take = 1'b0; fl_give = 1'b0; fl_give_idx = '0;
        live_inc = 1'b0; live_dec = 1'b0; rm_inc = 1'b0; walk_inc = 1'b0;
        unique case (st)
            ST_IDLE: if (fire) begin
                if (cmd_op == OP_INSERT) begin
                    fl_take = 1'b1; live_inc = 1'b1;
                end else if (cmd_op == OP_POP && head_vld[cmd_reg]) begin
                    fl_give = 1'b1; fl_give_idx = head_ptr[cmd_reg]; live_dec = 1'b1;
                end else if (cmd_op == OP_REMOVE && head_vld[cmd_reg]) begin
                    rm_inc = 1'b1;
                end
            end
            ST_WALK: begin
                if (w_match) begin
                    fl_give = 1'b1; fl_give_idx = w_cur; live_dec = 1'b1;
                end else if (cur_node.nxv) begin
                    walk_inc = 1'b1;
                end
            end
            ST_SWEEP: if (head_vld[w_reg]) begin
                fl_give = 1'b1; fl_give_idx = head_ptr[w_reg]; live_dec = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (st == ST_IDLE && fire && cmd_op == OP_INSERT) begin
            nodes[fl_top] <= '{tag: cmd_tag, nxt: head_ptr[cmd_reg], nxv: head_vld[cmd_reg]};
        end else if (st == ST_WALK && w_match && !w_athead) begin
            nodes[w_prev].nxt <= cur_node.nxt;
            nodes[w_prev].nxv <= cur_node.nxv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            head_vld <= '0; prod_vld <= '0;
            resp_valid <= 1'b0; resp_hit <= 1'b0; resp_tag <= '0; rm_miss <= 1'b0;
            w_reg <= '0; w_tag <= '0; w_cur <= '0; w_prev <= '0; w_athead <= 1'b0;
            for (int i = 0; i < NUM_REGS; i++) begin
                head_ptr[i] <= '0; prod_tag[i] <= '0;
            end
        end else begin
            resp_valid <= 1'b0;
            rm_miss    <= 1'b0;
            unique case (st)
                ST_IDLE: if (fire) begin
                    unique case (cmd_op)
                        OP_INSERT: begin
                            head_ptr[cmd_reg] <= fl_top;
                            head_vld[cmd_reg] <= 1'b1;
                        end
                        OP_POP: begin
                            resp_valid <= 1'b1;
                            resp_hit   <= head_vld[cmd_reg];
                            resp_tag   <= head_vld[cmd_reg] ? cmd_head.tag : '0;
                            if (head_vld[cmd_reg]) begin
                                head_ptr[cmd_reg] <= cmd_head.nxt;
                                head_vld[cmd_reg] <= cmd_head.nxv;
                            end
                        end
                        OP_SETP: begin
                            prod_vld[cmd_reg] <= 1'b1;
                            prod_tag[cmd_reg] <= cmd_tag;
                        end
                        OP_CLRP: prod_vld[cmd_reg] <= 1'b0;
                        OP_REMOVE: if (head_vld[cmd_reg]) begin
                            st <= ST_WALK;
                            w_reg <= cmd_reg; w_tag <= cmd_tag;
                            w_cur <= head_ptr[cmd_reg]; w_athead <= 1'b1;
                        end
                        OP_CLEAR: begin
                            st <= ST_SWEEP;
                            w_reg <= '0;
                        end
                        default: ;
                    endcase
                end
                ST_WALK: begin
                    if (w_match) begin
                        if (w_athead) begin
                            head_ptr[w_reg] <= cur_node.nxt;
                            head_vld[w_reg] <= cur_node.nxv;
                        end
                        st <= ST_IDLE;
                    end else if (cur_node.nxv) begin
                        w_prev <= w_cur; w_cur <= cur_node.nxt; w_athead <= 1'b0;
                    end else begin
                        rm_miss <= 1'b1;
                        st <= ST_IDLE;
                    end
                end
                ST_SWEEP: begin
                    prod_vld[w_reg] <= 1'b0;
                    if (head_vld[w_reg]) begin
                        head_ptr[w_reg] <= sweep_head.nxt;
                        head_vld[w_reg] <= sweep_head.nxv;
                    end else if (w_reg == REG_W'(NUM_REGS - 1)) begin
                        st <= ST_IDLE;
                    end else begin
                        w_reg <= w_reg + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    dtrk_freelist #(.DEPTH(POOL_DEPTH)) u_free (
        .clk(clk), .rst(rst), .take(fl_take), .give(fl_give), .give_idx(fl_give_idx),
        .top_idx(fl_top), .none_free(fl_empty), .free_cnt(fl_count)
    );
    dtrk_counter #(.W(CNT_W)) u_live (
        .clk(clk), .rst(rst), .inc(live_inc), .dec(live_dec), .value(live_count)
    );
    dtrk_counter #(.W(STAT_W)) u_rmcnt (
        .clk(clk), .rst(rst), .inc(rm_inc), .dec(1'b0), .value(remove_count)
    );
    dtrk_counter #(.W(STAT_W)) u_walkcnt (
        .clk(clk), .rst(rst), .inc(walk_inc), .dec(1'b0), .value(walk_count)
    );

    a_r11_pool_balance: assert property (@(posedge clk) disable iff (rst)
        (32'(live_count) + 32'(fl_count)) == 32'(POOL_DEPTH));
    a_r9_full_refuses_insert: assert property (@(posedge clk) disable iff (rst)
        (pool_full && cmd_op == OP_INSERT) |-> !cmd_ready);
    a_r2_resp_follows_pop: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(fire && cmd_op == OP_POP));
    a_r3_miss_pop_keeps_live: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> (live_count == $past(live_count)));
    a_r5_empty_means_no_nodes: assert property (@(posedge clk) disable iff (rst)
        all_empty |-> (live_count == '0));
    a_r8_miss_ends_walk: assert property (@(posedge clk) disable iff (rst)
        rm_miss |-> $past(st == ST_WALK));
    a_r6_long_op_stalls: assert property (@(posedge clk) disable iff (rst)
        (fire && is_long_op(cmd_op) && (cmd_op == OP_CLEAR || head_vld[cmd_reg])) |=> !cmd_ready);
endmodule

// File: tb/dep_tracker_test.sv
module dep_tracker_test;
    localparam int NR = 4;
    localparam int PD = 6;
    localparam int TW = 5;
    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [2:0] cmd_op = 3'd7;
    logic [1:0] cmd_reg = '0;
    logic [TW-1:0] cmd_tag = '0;
    logic resp_valid, resp_hit, rm_miss, pool_full, q_empty, q_prod_vld, all_empty;
    logic [TW-1:0] resp_tag, q_prod_tag;
    logic [1:0] q_reg = '0;
    logic [2:0] live_count;
    logic [SW-1:0] remove_count, walk_count;

    always #4 clk = ~clk;

    dep_tracker #(.NUM_REGS(NR), .POOL_DEPTH(PD), .TAG_W(TW), .STAT_W(SW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_tag(cmd_tag),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_tag(resp_tag),
        .rm_miss(rm_miss), .pool_full(pool_full), .q_reg(q_reg), .q_empty(q_empty),
        .q_prod_vld(q_prod_vld), .q_prod_tag(q_prod_tag), .all_empty(all_empty),
        .live_count(live_count), .remove_count(remove_count), .walk_count(walk_count)
    );

    int nchk = 0, nbad = 0;
    int mcnt [NR];
    int mtag [NR][8];
    int mpv [NR];
    int mpt [NR];
    int exp_rm = 0, exp_walk = 0, next_tag = 0;
    int last_stall = 0;
    logic last_miss = 1'b0;
    logic got_rv, got_hit;
    int got_tag;

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    function automatic int total_live();
        int s = 0;
        for (int r = 0; r < NR; r++) s += mcnt[r];
        return s;
    endfunction

    task automatic check_state(input string req);
        for (int r = 0; r < NR; r++) begin
            q_reg = 2'(r);
            #0.5;
            chk({req, " R5 q_empty"}, int'(q_empty), (mcnt[r] == 0) ? 1 : 0);
            chk({req, " R4 q_prod_vld"}, int'(q_prod_vld), mpv[r]);
            if (mpv[r] != 0) chk({req, " R4 q_prod_tag"}, int'(q_prod_tag), mpt[r]);
        end
        chk({req, " R5 all_empty"}, int'(all_empty), (total_live() == 0) ? 1 : 0);
        chk({req, " R11 live_count"}, int'(live_count), total_live());
        chk({req, " R6 remove_count"}, int'(remove_count), exp_rm);
        chk({req, " R6 walk_count"}, int'(walk_count), exp_walk);
    endtask

    task automatic send(input logic [2:0] op, input int r, input int tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_reg = 2'(r); cmd_tag = TW'(tag);
        #1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1;
        got_rv = resp_valid; got_hit = resp_hit; got_tag = int'(resp_tag);
        cmd_valid = 1'b0; cmd_op = 3'd7;
        last_stall = 0; last_miss = rm_miss;
        while (!cmd_ready) begin
            @(posedge clk);
            #1;
            last_stall++;
            last_miss = last_miss | rm_miss;
        end
    endtask

    task automatic m_insert(input int r);
        next_tag = (next_tag % 31) + 1;
        send(3'd0, r, next_tag);
        mtag[r][mcnt[r]] = next_tag;
        mcnt[r]++;
    endtask

    task automatic m_pop(input int r);
        send(3'd1, r, 0);
        chk("R2 resp_valid", int'(got_rv), 1);
        if (mcnt[r] > 0) begin
            chk("R2 resp_hit", int'(got_hit), 1);
            chk("R2 resp_tag newest", got_tag, mtag[r][mcnt[r]-1]);
            mcnt[r]--;
        end else begin
            chk("R3 resp_hit on empty", int'(got_hit), 0);
        end
    endtask

    task automatic m_remove(input int r, input int tag);
        int idx;
        idx = -1;
        for (int i = mcnt[r] - 1; i >= 0; i--)
            if (idx < 0 && mtag[r][i] == tag) idx = i;
        send(3'd4, r, tag);
        if (mcnt[r] == 0) begin
            chk("R7 remove on empty stall", last_stall, 0);
            chk("R7 remove on empty miss", int'(last_miss), 0);
        end else if (idx < 0) begin
            exp_rm++;
            exp_walk += mcnt[r] - 1;
            chk("R8 stall on miss", last_stall, mcnt[r]);
            chk("R8 rm_miss pulse", int'(last_miss), 1);
        end else begin
            exp_rm++;
            exp_walk += mcnt[r] - 1 - idx;
            chk("R6 remove stall", last_stall, mcnt[r] - idx);
            chk("R6 no miss", int'(last_miss), 0);
            for (int i = idx; i < mcnt[r] - 1; i++) mtag[r][i] = mtag[r][i+1];
            mcnt[r]--;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired R1 actual=hung expected=done");
        finish_up();
    end

    initial begin
        for (int r = 0; r < NR; r++) begin mcnt[r] = 0; mpv[r] = 0; mpt[r] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 ready after reset", int'(cmd_ready), 1);
        chk("R1 pool_full after reset", int'(pool_full), 0);
        check_state("R1");

        // R4: producer slot writes leave chains alone
        send(3'd2, 2, 9); mpv[2] = 1; mpt[2] = 9;
        check_state("R4 set");
        m_insert(2);
        send(3'd2, 2, 17); mpt[2] = 17;
        send(3'd3, 0, 0);
        check_state("R4 set with chain");
        send(3'd3, 2, 0); mpv[2] = 0;
        check_state("R4 clear");

        // R9: fill the pool
        m_insert(0); m_insert(0); m_insert(1); m_insert(3); m_insert(3);
        check_state("R9 filled");
        chk("R9 pool_full", int'(pool_full), 1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_reg = 2'd1; cmd_tag = 5'd30;
        #1;
        chk("R9 insert refused", int'(cmd_ready), 0);
        @(posedge clk); #1;
        chk("R9 live unchanged", int'(live_count), PD);
        cmd_valid = 1'b0; cmd_op = 3'd7;
        m_pop(3);
        chk("R9 not full after pop", int'(pool_full), 0);

        // R2 / R3: drain every register past empty
        for (int r = 0; r < NR; r++) begin
            for (int k = 0; k < 4; k++) m_pop(r);
            check_state("R2 drain");
        end

        // R6: remove from each position of a four-node chain
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) m_insert(1);
            m_remove(1, mtag[1][3 - p]);
            check_state("R6 after remove");
            for (int k = 0; k < 4; k++) m_pop(1);
        end
        m_remove(1, 5);
        check_state("R7 empty remove");
        for (int k = 0; k < 3; k++) m_insert(2);
        m_remove(2, 0);
        check_state("R8 miss");
        m_remove(2, mtag[2][0]);
        check_state("R6 tail remove");

        // R10: clear everything
        m_insert(0); m_insert(3);
        send(3'd2, 1, 4); mpv[1] = 1; mpt[1] = 4;
        send(3'd2, 3, 6); mpv[3] = 1; mpt[3] = 6;
        begin
            int expect_stall;
            expect_stall = NR + total_live();
            send(3'd5, 0, 0);
            chk("R10 clear stall", last_stall, expect_stall);
        end
        for (int r = 0; r < NR; r++) begin mcnt[r] = 0; mpv[r] = 0; end
        check_state("R10 cleared");
        for (int k = 0; k < PD; k++) m_insert(k % NR);
        chk("R10 pool reusable full", int'(pool_full), 1);
        check_state("R10 refill");
        send(3'd6, 0, 0);
        check_state("R4 unused op");

        finish_up();
    end
endmodule